// File: doc/BRIEF.md
# USB Frame Timer with Done-Queue Interrupt Delay

This block keeps frame time for a full-speed USB host controller. While the controller's functional state is operational, it counts bit-time ticks down from a programmable 14-bit interval. Each time the count runs out, it closes the frame: it advances a 16-bit frame number, copies the interval toggle into the remaining-time toggle, and reloads the count. Every frame start produces a start-of-frame strobe. Every frame close also produces a boundary strobe, and the low five bits of the frame number select the periodic list entry for the next frame.

A second counter decides when the done queue is handed back to software. Every completed transfer can shorten the wait to its own 3-bit frame delay. At a frame close, an expired wait raises a writeback request and a writeback-done event, unless the done status is still pending from earlier. Memory traffic and list walking are handled by neighbouring blocks, which consume the strobes and the index.

Top module: `usb_frame_timer`

## Requirements
- R1: A one-cycle `cfg_wr_en` updates the interval word. Bits 13:0 hold the interval, bits 30:16 hold the full-speed maximum packet size and bit 31 holds the interval toggle. Bits 15:14 are not stored and read back as 0 on `interval_rd`.
- R2: After reset `interval_rd` is 0x27782EDF (interval 11999, packet size 0x2778, toggle 0), the frame number and remaining count are 0, and the done delay is 7.
- R3: `remaining_rd` carries the remaining-time toggle in bit 31 and the count in bits 13:0. The count reads as 0 whenever `hc_state` is not operational (2'b10).
- R4: On the first cycle in the operational state, the count loads the interval and `sof_pulse` rises. After that the count drops by one on each `bit_tick` and holds while `bit_tick` is low, so a frame lasts interval+1 ticks.
- R5: A tick that arrives while the count is 0 closes the frame. The count reloads, the frame number rises by 1 modulo 2^16, the remaining toggle takes the interval toggle, and `bnd_pulse` and `sof_pulse` are both high for one cycle.
- R6: `periodic_index` equals bits 4:0 of the frame number.
- R7: `fno_pulse` is high together with `bnd_pulse` exactly when bit 15 of the frame number changed at that boundary.
- R8: The done delay starts at 7. A `td_done` whose `td_delay` is smaller than the current value lowers the counter to `td_delay`. A larger or equal value leaves it unchanged.
- R9: At a frame close with the delay at 0 and `wd_pending` low, `wb_req` and `wd_set` are high for one cycle and the delay returns to 7. With `wd_pending` high the delay stays at 0. Values from 1 to 6 drop by 1, and 7 stays 7.
- R10: The state encodings are reset 2'b00, resume 2'b01, operational 2'b10 and suspend 2'b11. Outside the operational state no strobe is produced and the frame number holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hc_state | input | 2 | Controller functional state |
| bit_tick | input | 1 | One pulse per full-speed bit time |
| cfg_wr_en | input | 1 | Write strobe for the interval word |
| cfg_wr_data | input | 32 | Interval word write data |
| td_done | input | 1 | A transfer was retired this cycle |
| td_delay | input | DLY_W | Frame delay field of the retired transfer |
| wd_pending | input | 1 | Writeback-done status is still set |
| interval_rd | output | 32 | Interval word read value |
| remaining_rd | output | 32 | Remaining-time word read value |
| frame_num_rd | output | 32 | Frame number word read value |
| done_delay | output | DLY_W | Current done-queue delay |
| periodic_index | output | IDX_W | Periodic list entry for the current frame |
| sof_pulse | output | 1 | Start-of-frame strobe |
| bnd_pulse | output | 1 | Frame boundary strobe |
| fno_pulse | output | 1 | Frame number bit 15 toggled |
| wb_req | output | 1 | Request to write back the done head |
| wd_set | output | 1 | Raise writeback-done status |

## Verification
The assertions assume that `wd_pending` reflects a status that this block raised earlier. They also assume that `td_done` and `td_delay` are sampled only when `td_done` is high. They place no limits on `hc_state` or `bit_tick`, so any state change or tick gap is legal. The stimulus changes `hc_state`, retires transfers and toggles `wd_pending` only in the cycles just after an observed boundary, never in a cycle where a frame closes. This keeps the order of delay-lowering and boundary decrement unambiguous for the expected values. Interval writes are made only while frame generation is stopped, so each new frame length starts cleanly at the next entry into the operational state.

// File: rtl/usb_ft_pkg.sv
package usb_ft_pkg;

    typedef enum logic [1:0] {
        HC_RESET   = 2'b00,
        HC_RESUME  = 2'b01,
        HC_OPER    = 2'b10,
        HC_SUSPEND = 2'b11
    } hc_state_e;

    localparam int WORD_W = 32;

endpackage

// File: rtl/ft_remain_ctr.sv
module ft_remain_ctr #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] remain,
    output logic             wrap,
    output logic             start
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             live;
    } ctr_t;

    ctr_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        start     = run && !st_q.live;
        wrap      = run && st_q.live && tick && (st_q.cnt == '0);
        st_d.live = run;
        if (start || wrap) begin
            st_d.cnt = reload;
        end else if (run && tick) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{cnt: '0, live: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign remain = st_q.cnt;

endmodule

// File: rtl/ft_done_delay.sv
module ft_done_delay #(
    parameter int DLY_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             boundary,
    input  logic             td_done,
    input  logic [DLY_W-1:0] td_delay,
    input  logic             wd_pending,
    output logic [DLY_W-1:0] delay,
    output logic             fire
);

    localparam logic [DLY_W-1:0] DLY_IDLE = '1;

    typedef struct packed {
        logic [DLY_W-1:0] cnt;
        logic             fire;
    } dly_t;

    dly_t             st_d, st_q;
    logic [DLY_W-1:0] lowered;

    always_comb begin
        lowered   = (td_done && (td_delay < st_q.cnt)) ? td_delay : st_q.cnt;
        st_d.cnt  = lowered;
        st_d.fire = 1'b0;
        if (boundary) begin
            if ((lowered == '0) && !wd_pending) begin
                st_d.cnt  = DLY_IDLE;
                st_d.fire = 1'b1;
            end else if ((lowered != DLY_IDLE) && (lowered != '0)) begin
                st_d.cnt = lowered - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{cnt: DLY_IDLE, fire: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign delay = st_q.cnt;
    assign fire  = st_q.fire;

endmodule

// File: rtl/usb_frame_timer.sv
module usb_frame_timer
    import usb_ft_pkg::*;
#(
    parameter int IVL_W          = 14,
    parameter int MPS_W          = 15,
    parameter int FNUM_W         = 16,
    parameter int DLY_W          = 3,
    parameter int PERIODIC_SLOTS = 32,
    parameter int RST_IVL        = 11999,
    parameter int RST_MPS        = 'h2778,
    localparam int IDX_W         = $clog2(PERIODIC_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        hc_state,
    input  logic              bit_tick,
    input  logic              cfg_wr_en,
    input  logic [WORD_W-1:0] cfg_wr_data,
    input  logic              td_done,
    input  logic [DLY_W-1:0]  td_delay,
    input  logic              wd_pending,
    output logic [WORD_W-1:0] interval_rd,
    output logic [WORD_W-1:0] remaining_rd,
    output logic [WORD_W-1:0] frame_num_rd,
    output logic [DLY_W-1:0]  done_delay,
    output logic [IDX_W-1:0]  periodic_index,
    output logic              sof_pulse,
    output logic              bnd_pulse,
    output logic              fno_pulse,
    output logic              wb_req,
    output logic              wd_set
);

    localparam int MPS_LSB = 16;
    localparam int TGL_BIT = WORD_W - 1;
    localparam logic [WORD_W-1:0] IVL_MASK = (WORD_W'(1) << IVL_W) - 1;
    localparam logic [WORD_W-1:0] MPS_MASK = ((WORD_W'(1) << MPS_W) - 1) << MPS_LSB;
    localparam logic [WORD_W-1:0] WR_MASK  = (WORD_W'(1) << TGL_BIT) | MPS_MASK | IVL_MASK;
    localparam logic [WORD_W-1:0] WORD_RST = ((WORD_W'(RST_MPS) << MPS_LSB) & MPS_MASK)
                                           | (WORD_W'(RST_IVL) & IVL_MASK);

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              frt;
        logic [FNUM_W-1:0] fnum;
        logic              sof;
        logic              bnd;
        logic              fno;
    } tmr_t;

    tmr_t              st_d, st_q;
    logic              run;
    logic              wrap_w;
    logic              start_w;
    logic [IVL_W-1:0]  remain_w;
    logic [FNUM_W-1:0] fnum_inc;

    assign run = (hc_state == HC_OPER);

    ft_remain_ctr #(.CNT_W(IVL_W)) i_remain (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .tick   (bit_tick),
        .reload (st_q.word[IVL_W-1:0]),
        .remain (remain_w),
        .wrap   (wrap_w),
        .start  (start_w)
    );

    ft_done_delay #(.DLY_W(DLY_W)) i_delay (
        .clk        (clk),
        .rst_n      (rst_n),
        .boundary   (wrap_w),
        .td_done    (td_done),
        .td_delay   (td_delay),
        .wd_pending (wd_pending),
        .delay      (done_delay),
        .fire       (wb_req)
    );

    always_comb begin
        fnum_inc = st_q.fnum + 1'b1;
        st_d     = st_q;
        st_d.sof = 1'b0;
        st_d.bnd = 1'b0;
        st_d.fno = 1'b0;
        if (cfg_wr_en) begin
            st_d.word = cfg_wr_data & WR_MASK;
        end
        if (start_w) begin
            st_d.sof = 1'b1;
        end
        if (wrap_w) begin
            st_d.fnum = fnum_inc;
            st_d.frt  = st_q.word[TGL_BIT];
            st_d.sof  = 1'b1;
            st_d.bnd  = 1'b1;
            st_d.fno  = fnum_inc[FNUM_W-1] ^ st_q.fnum[FNUM_W-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{word: WORD_RST, frt: 1'b0, fnum: '0,
                      sof: 1'b0, bnd: 1'b0, fno: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        remaining_rd          = '0;
        remaining_rd[TGL_BIT] = st_q.frt;
        if (run) begin
            remaining_rd[IVL_W-1:0] = remain_w;
        end
    end

    assign interval_rd    = st_q.word;
    assign frame_num_rd   = WORD_W'(st_q.fnum);
    assign periodic_index = st_q.fnum[IDX_W-1:0];
    assign sof_pulse      = st_q.sof;
    assign bnd_pulse      = st_q.bnd;
    assign fno_pulse      = st_q.fno;
    assign wd_set         = wb_req;

endmodule

// File: rtl/usb_frame_timer_chk.sv
module usb_frame_timer_chk
    import usb_ft_pkg::*;
#(
    parameter int FNUM_W = 16,
    parameter int DLY_W  = 3,
    parameter int IVL_W  = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        hc_state,
    input logic              bnd_pulse,
    input logic              sof_pulse,
    input logic              fno_pulse,
    input logic              wb_req,
    input logic              wd_set,
    input logic [FNUM_W-1:0] frame_num,
    input logic [IVL_W-1:0]  remain_cnt,
    input logic [DLY_W-1:0]  done_delay
);

    assert_fnum_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bnd_pulse |-> frame_num == FNUM_W'($past(frame_num) + 1'b1));

    assert_sof_with_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bnd_pulse |-> sof_pulse);

    assert_fnum_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !bnd_pulse |-> frame_num == $past(frame_num));

    assert_quiet_when_stopped_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (hc_state != HC_OPER) |=> (!bnd_pulse && !sof_pulse));

    assert_idle_count_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hc_state != HC_OPER) |-> remain_cnt == '0);

    assert_fno_on_msb_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fno_pulse |-> (bnd_pulse && (frame_num[FNUM_W-1] != $past(frame_num[FNUM_W-1]))));

    assert_wb_at_boundary_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req |-> (bnd_pulse && wd_set && (done_delay == '1)));

    assert_delay_no_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !wb_req |-> done_delay <= $past(done_delay));

endmodule

bind usb_frame_timer usb_frame_timer_chk #(
    .FNUM_W (FNUM_W),
    .DLY_W  (DLY_W),
    .IVL_W  (IVL_W)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hc_state   (hc_state),
    .bnd_pulse  (bnd_pulse),
    .sof_pulse  (sof_pulse),
    .fno_pulse  (fno_pulse),
    .wb_req     (wb_req),
    .wd_set     (wd_set),
    .frame_num  (frame_num_rd[FNUM_W-1:0]),
    .remain_cnt (remaining_rd[IVL_W-1:0]),
    .done_delay (done_delay)
);

// File: tb/test_usb_frame_timer.sv
`timescale 1ns/1ps
module test_usb_frame_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  hc_state = 2'b00;
    logic        bit_tick = 1'b1;
    logic        cfg_wr_en = 1'b0;
    logic [31:0] cfg_wr_data = '0;
    logic        td_done = 1'b0;
    logic [2:0]  td_delay = '0;
    logic        wd_pending = 1'b0;
    logic [31:0] interval_rd, remaining_rd, frame_num_rd;
    logic [2:0]  done_delay;
    logic [4:0]  periodic_index;
    logic        sof_pulse, bnd_pulse, fno_pulse, wb_req, wd_set;

    usb_frame_timer i_usb_frame_timer (
        .clk(clk), .rst_n(rst_n), .hc_state(hc_state), .bit_tick(bit_tick),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data), .td_done(td_done),
        .td_delay(td_delay), .wd_pending(wd_pending), .interval_rd(interval_rd),
        .remaining_rd(remaining_rd), .frame_num_rd(frame_num_rd),
        .done_delay(done_delay), .periodic_index(periodic_index),
        .sof_pulse(sof_pulse), .bnd_pulse(bnd_pulse), .fno_pulse(fno_pulse),
        .wb_req(wb_req), .wd_set(wd_set)
    );

    always #2 clk = ~clk;

    typedef struct {
        int fnum;
        bit wb;
        bit fno;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail = 0;
    int   sof_seen = 0;
    int   bnd_seen = 0;
    int   m_fnum = 0;
    int   m_dly = 7;
    bit   m_pend = 1'b0;
    int   m_sof = 0;
    bit   finished = 1'b0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Expected outcome of one frame close, from R5, R7 and R9.
    task automatic push_boundary();
        exp_t e;
        int   nf;
        nf    = (m_fnum + 1) % 65536;
        e.fnum = nf;
        e.fno  = ((nf >> 15) & 1) != ((m_fnum >> 15) & 1);
        e.wb   = 1'b0;
        if (m_dly == 0 && !m_pend) begin
            e.wb  = 1'b1;
            m_dly = 7;
        end else if (m_dly != 7 && m_dly != 0) begin
            m_dly--;
        end
        m_fnum = nf;
        m_sof++;
        exp_q.push_back(e);
    endtask

    task automatic wait_bnd(input int k);
        int target;
        target = bnd_seen + k;
        while (bnd_seen < target) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic write_ivl(input logic [31:0] w);
        cfg_wr_data = w;
        cfg_wr_en   = 1'b1;
        @(negedge clk);
        cfg_wr_en   = 1'b0;
        @(negedge clk);
    endtask

    task automatic retire(input logic [2:0] d);
        td_delay = d;
        td_done  = 1'b1;
        if (d < m_dly) m_dly = d;
        @(negedge clk);
        td_done = 1'b0;
        @(negedge clk);
    endtask

    // Monitor: pops one expected item per observed frame close.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (sof_pulse) sof_seen++;
            if (bnd_pulse) begin
                bnd_seen++;
                if (exp_q.size() == 0) begin
                    check("R10 unexpected boundary", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check("R5 frame number", frame_num_rd, e.fnum);
                    check("R5 sof at boundary", {31'd0, sof_pulse}, 32'd1);
                    check("R6 periodic index", {27'd0, periodic_index}, e.fnum & 31);
                    check("R7 overflow strobe", {31'd0, fno_pulse}, {31'd0, e.fno});
                    check("R9 writeback request", {31'd0, wb_req}, {31'd0, e.wb});
                    check("R9 writeback done", {31'd0, wd_set}, {31'd0, e.wb});
                end
            end else if (fno_pulse || wb_req || wd_set) begin
                check("R7 R9 strobe without boundary", 32'd1, 32'd0);
            end
        end
    end

    initial begin
        #(4 * 190000);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int n_wrap;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 reset values
        check("R2 interval word", interval_rd, 32'h2778_2EDF);
        check("R2 remaining", remaining_rd, 32'h0);
        check("R2 frame number", frame_num_rd, 32'h0);
        check("R2 done delay", {29'd0, done_delay}, 32'd7);
        check("R2 periodic index", {27'd0, periodic_index}, 32'd0);

        // R1 interval word layout
        write_ivl(32'hA000_0007);
        check("R1 readback", interval_rd, 32'hA000_0007);
        write_ivl(32'hFFFF_FFFF);
        check("R1 reserved bits", interval_rd, 32'hFFFF_3FFF);
        write_ivl(32'h8000_0007);
        check("R1 final word", interval_rd, 32'h8000_0007);

        // R3 R10 non-operational states
        hc_state = 2'b11;
        repeat (5) @(negedge clk);
        check("R3 suspend count", remaining_rd, 32'h0);
        hc_state = 2'b01;
        repeat (5) @(negedge clk);
        check("R3 resume count", remaining_rd, 32'h0);
        check("R10 no sof outside operational", sof_seen, 32'd0);
        hc_state = 2'b00;

        // R8 lowering rule
        retire(3'd5);
        check("R8 lower to 5", {29'd0, done_delay}, 32'd5);
        retire(3'd6);
        check("R8 larger ignored", {29'd0, done_delay}, 32'd5);
        retire(3'd5);
        check("R8 equal ignored", {29'd0, done_delay}, 32'd5);

        // R4 start and countdown, R9 countdown 5..0 then fire
        for (int i = 0; i < 7; i++) push_boundary();
        m_sof++;
        hc_state = 2'b10;
        @(negedge clk);
        check("R4 sof on entry", {31'd0, sof_pulse}, 32'd1);
        check("R4 loaded count", remaining_rd, 32'h0000_0007);
        @(negedge clk);
        check("R4 one tick", remaining_rd, 32'h0000_0006);
        bit_tick = 1'b0;
        repeat (3) @(negedge clk);
        check("R4 hold without tick", remaining_rd, 32'h0000_0006);
        bit_tick = 1'b1;
        wait_bnd(1);
        check("R5 toggle copied", {31'd0, remaining_rd[31]}, 32'd1);
        wait_bnd(6);
        check("R9 delay back to idle", {29'd0, done_delay}, 32'd7);

        // R9 pending status holds the counter at 0
        retire(3'd0);
        check("R8 lower to 0", {29'd0, done_delay}, 32'd0);
        wd_pending = 1'b1;
        m_pend     = 1'b1;
        push_boundary();
        push_boundary();
        wait_bnd(2);
        check("R9 held while pending", {29'd0, done_delay}, 32'd0);
        wd_pending = 1'b0;
        m_pend     = 1'b0;
        push_boundary();
        push_boundary();
        wait_bnd(2);
        check("R9 fired after pending", {29'd0, done_delay}, 32'd7);

        // R10 stop: frame number holds, count reads 0, toggle kept
        hc_state = 2'b00;
        repeat (20) @(negedge clk);
        check("R10 frame held", frame_num_rd, m_fnum);
        check("R3 stopped word", remaining_rd, 32'h8000_0000);

        // R5 toggle follows a new interval toggle
        write_ivl(32'h0000_0003);
        push_boundary();
        m_sof++;
        hc_state = 2'b10;
        @(negedge clk);
        check("R5 old toggle before boundary", remaining_rd, 32'h8000_0003);
        wait_bnd(1);
        check("R5 toggle cleared", {31'd0, remaining_rd[31]}, 32'd0);
        hc_state = 2'b00;
        repeat (4) @(negedge clk);

        // R7 R6 one-tick frames through bit 15 change and wrap
        write_ivl(32'h0000_0000);
        n_wrap = 65536 - m_fnum + 3;
        for (int i = 0; i < n_wrap; i++) push_boundary();
        m_sof++;
        hc_state = 2'b10;
        repeat (n_wrap + 1) @(negedge clk);
        hc_state = 2'b00;
        repeat (4) @(negedge clk);
        check("R5 wrapped frame number", frame_num_rd, m_fnum);
        check("R6 index after wrap", {27'd0, periodic_index}, m_fnum & 31);
        check("R5 all boundaries seen", exp_q.size(), 32'd0);
        check("R4 R5 sof count", sof_seen, m_sof);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule